// File: doc/BRIEF.md
# Hysteretic charge current modulator

This block produces the single gate signal that switches charge current into a battery. Its behaviour depends on the charge phase reported by the surrounding charge controller. During fast charge it is a bang-bang current regulator: two comparator flags say whether the sensed current is under the lower bound or over the upper bound. The gate turns on for the first, turns off for the second, and keeps its level in the band between them. When the charger gates an externally regulated source, fast charge simply holds the gate on.

Around fast charge the block times pulse trains from a microsecond tick. During the hold-off window and during top-off, the gate is on for a short slot and then off for seven times as long, which gives one eighth of the fast rate on average. During maintenance trickle it sends one short slot per selectable period, giving roughly C/512.

A trickle-period selection of zero, or a display-mode inhibit, suppresses both top-off and trickle current. An over-voltage flag blanks the output in the same cycle it is seen. Every phase change restarts the slot timer, so each train begins with a full on-slot.

Top module: `charge_gate_mod`

## Requirements
- R1: While rstN is low, and on the first cycle after it rises, gateOut is 0.
- R2: In phase code 3 (fast charge) with extGate=0, each clock edge sets the gate as follows:
  - to 1 when senseLow=1, and senseLow wins when both flags are set;
  - to 0 when only senseHigh=1;
  - to its previous level when neither flag is set.
  The previous level counts as 0 on the first cycle of the phase.
- R3: In phase code 3 with extGate=1, the gate is 1 at the edge after each cycle of the phase, whatever the sense flags are.
- R4: In phase code 2 (hold-off) and phase code 4 (top-off), the gate is on for ON_US counted ticks and off for OFF_US counted ticks, repeating. The on-slot begins at the first edge of the phase.
- R5: In phase code 5 (trickle), the gate is on for ON_US ticks out of a period of TRICKLE_BASE_US << (trickleSel-1) ticks. trickleSel codes 1, 2 and 3 select 1x, 2x and 4x the base period.
- R6: When trickleSel=0 or displayInhibit=1, the gate stays 0 in phase codes 4 and 5. Hold-off (code 2) is unaffected.
- R7: overVolt=1 drives gateOut to 0 in the same cycle, with no clock edge needed. It also clears the level that R2 would otherwise hold.
- R8: Phase codes 0 (idle), 1 (discharge), 6 (complete) and 7 (inhibit) give gate 0 at the following edge.
- R9: Any change of phase code restarts the slot timer. A train entered directly from another pulsed phase starts with a fresh on-slot.
- R10: The slot timer advances only on edges where usTick=1. Without ticks, a pulsed phase keeps its gate level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| phaseIn | input | 3 | Charge phase code (see R2 to R8) |
| extGate | input | 1 | 1 selects gating of an external regulated source |
| usTick | input | 1 | One-cycle strobe per microsecond |
| trickleSel | input | 2 | Trickle period select; 0 disables top-off and trickle |
| displayInhibit | input | 1 | Display mode that suppresses top-off and trickle |
| senseLow | input | 1 | Sensed current below lower threshold |
| senseHigh | input | 1 | Sensed current above upper threshold |
| overVolt | input | 1 | Cell voltage above the maximum limit |
| gateOut | output | 1 | Charge current gate |

## Verification
A slot timer with the wrong count shows up at gateOut as an on-slot that is one or more ticks too long or too short. This appears within one train period after the phase starts, because the bench compares every edge against an independently counted slot position. A missed restart on a phase change shows up on the very first edge of the new phase as a 0 where a fresh on-slot is due. A wrong held level in fast charge shows up on the first cycle where neither comparator flag is set. The immediate over-voltage blanking is checked between clock edges, so a registered-only path is caught in the cycle it occurs.

// File: rtl/cgm_pkg.sv
package cgm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_DISCHARGE = 3'd1,
    PH_HOLDOFF   = 3'd2,
    PH_FAST      = 3'd3,
    PH_TOPOFF    = 3'd4,
    PH_TRICKLE   = 3'd5,
    PH_DONE      = 3'd6,
    PH_INHIBIT   = 3'd7
  } chargePhase_e;

  // strobes from control to the slot timer
  typedef struct packed {
    logic       restart;     // phase changed this cycle
    logic       runCount;    // a pulsed phase is active
    logic       useTrickle;  // pick the trickle period
    logic [1:0] periodSel;   // trickle period code
  } timerStrobe_t;

endpackage

// File: rtl/cgm_slot_timer.sv
module cgm_slot_timer
  import cgm_pkg::*;
#(
  parameter int ON_US           = 260,
  parameter int OFF_US          = 1820,
  parameter int TRICKLE_BASE_US = 133120
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         usTick,
  input  timerStrobe_t strobe,
  output logic         onWindow
);

  localparam int TRAIN_PERIOD = ON_US + OFF_US;
  localparam int MAX_TRICKLE  = TRICKLE_BASE_US * 4;
  localparam int MAX_PERIOD   = (MAX_TRICKLE > TRAIN_PERIOD) ? MAX_TRICKLE : TRAIN_PERIOD;
  localparam int CNT_W        = $clog2(MAX_PERIOD + 1);
  localparam int SEL_CODES    = 4;

  logic [CNT_W-1:0] lastTbl [SEL_CODES];
  logic [CNT_W-1:0] curLast;
  logic [CNT_W-1:0] cnt;

  // per select code, last count value of the period
  for (genvar g = 0; g < SEL_CODES; g++) begin : g_period
    if (g == 0) begin : g_train
      assign lastTbl[g] = CNT_W'(TRAIN_PERIOD - 1);
    end else begin : g_trickle
      localparam int P = TRICKLE_BASE_US << (g - 1);
      assign lastTbl[g] = CNT_W'(P - 1);
    end
  end

  always_comb begin
    if (strobe.useTrickle) curLast = lastTbl[strobe.periodSel];
    else                   curLast = lastTbl[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.restart) begin
      cnt <= '0;
    end else if (strobe.runCount && usTick) begin
      if (cnt >= curLast) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end

  assign onWindow = (cnt < CNT_W'(ON_US));

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (cnt == '0));

  // R4
  train_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runCount && !strobe.useTrickle && !strobe.restart) |-> (cnt <= CNT_W'(TRAIN_PERIOD - 1)));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!usTick && !strobe.restart) |=> $stable(cnt));

endmodule

// File: rtl/cgm_gate_ctrl.sv
module cgm_gate_ctrl
  import cgm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  chargePhase_e phase,
  input  logic         extGate,
  input  logic [1:0]   trickleSel,
  input  logic         displayInhibit,
  input  logic         senseLow,
  input  logic         senseHigh,
  input  logic         overVolt,
  input  logic         onWindow,
  output timerStrobe_t strobe,
  output logic         gateOut
);

  chargePhase_e prevPhase;
  logic         restart;
  logic         maintEnable;
  logic         pulseLevel;
  logic         heldLevel;
  logic         quietPhase;
  logic         nextGate;
  logic         gateReg;

  assign restart     = (phase != prevPhase);
  assign maintEnable = (trickleSel != 2'd0) && !displayInhibit;
  assign pulseLevel  = restart ? 1'b1 : onWindow;
  assign heldLevel   = restart ? 1'b0 : gateReg;
  assign quietPhase  = (phase == PH_IDLE) || (phase == PH_DISCHARGE) ||
                       (phase == PH_DONE) || (phase == PH_INHIBIT);

  always_comb begin
    strobe.restart    = restart;
    strobe.runCount   = (phase == PH_HOLDOFF) || (phase == PH_TOPOFF) || (phase == PH_TRICKLE);
    strobe.useTrickle = (phase == PH_TRICKLE);
    strobe.periodSel  = trickleSel;
  end

  always_comb begin
    unique case (phase)
      PH_FAST: begin
        if (extGate)        nextGate = 1'b1;
        else if (senseLow)  nextGate = 1'b1;
        else if (senseHigh) nextGate = 1'b0;
        else                nextGate = heldLevel;
      end
      PH_HOLDOFF: nextGate = pulseLevel;
      PH_TOPOFF,
      PH_TRICKLE: nextGate = maintEnable && pulseLevel;
      default:    nextGate = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPhase <= PH_IDLE;
      gateReg   <= 1'b0;
    end else begin
      prevPhase <= phase;
      gateReg   <= nextGate && !overVolt;
    end
  end

  assign gateOut = gateReg && !overVolt;

  // R7
  overvolt_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    overVolt |-> !gateOut);

  // R8
  quiet_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    quietPhase |=> !gateReg);

  // R2
  switch_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FAST && !extGate && senseLow && !overVolt) |=> gateReg);

  // R2
  switch_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FAST && !extGate && !senseLow && senseHigh) |=> !gateReg);

  // R3
  gated_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FAST && extGate && !overVolt) |=> gateReg);

  // R6
  maint_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_TOPOFF || phase == PH_TRICKLE) && !maintEnable) |=> !gateReg);

  // R4
  first_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restart && phase == PH_HOLDOFF && !overVolt) |=> gateReg);

endmodule

// File: rtl/charge_gate_mod.sv
module charge_gate_mod
  import cgm_pkg::*;
#(
  parameter int ON_US           = 260,
  parameter int OFF_US          = 1820,
  parameter int TRICKLE_BASE_US = 133120
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] phaseIn,
  input  logic       extGate,
  input  logic       usTick,
  input  logic [1:0] trickleSel,
  input  logic       displayInhibit,
  input  logic       senseLow,
  input  logic       senseHigh,
  input  logic       overVolt,
  output logic       gateOut
);

  timerStrobe_t strobe;
  logic         onWindow;
  chargePhase_e phase;

  assign phase = chargePhase_e'(phaseIn);

  cgm_gate_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .phase          (phase),
    .extGate        (extGate),
    .trickleSel     (trickleSel),
    .displayInhibit (displayInhibit),
    .senseLow       (senseLow),
    .senseHigh      (senseHigh),
    .overVolt       (overVolt),
    .onWindow       (onWindow),
    .strobe         (strobe),
    .gateOut        (gateOut)
  );

  cgm_slot_timer #(
    .ON_US           (ON_US),
    .OFF_US          (OFF_US),
    .TRICKLE_BASE_US (TRICKLE_BASE_US)
  ) u_timer (
    .clk      (clk),
    .rstN     (rstN),
    .usTick   (usTick),
    .strobe   (strobe),
    .onWindow (onWindow)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rstN |=> !gateOut);

endmodule

// File: tb/charge_gate_mod_test.sv
module charge_gate_mod_test;

  localparam int CLK_PERIOD = 10;
  localparam int T_ON   = 3;
  localparam int T_OFF  = 21;
  localparam int T_BASE = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] phaseIn = 3'd0;
  logic       extGate = 1'b0;
  logic       usTick = 1'b0;
  logic [1:0] trickleSel = 2'd0;
  logic       displayInhibit = 1'b0;
  logic       senseLow = 1'b0;
  logic       senseHigh = 1'b0;
  logic       overVolt = 1'b0;
  logic       gateOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model state
  int   mPos = 0;
  logic mReg = 1'b0;
  int   mLast = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  charge_gate_mod #(
    .ON_US(T_ON), .OFF_US(T_OFF), .TRICKLE_BASE_US(T_BASE)
  ) uut (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .extGate(extGate),
    .usTick(usTick), .trickleSel(trickleSel), .displayInhibit(displayInhibit),
    .senseLow(senseLow), .senseHigh(senseHigh), .overVolt(overVolt),
    .gateOut(gateOut)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: gateOut=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int periodOf(input int ph, input logic [1:0] sel);
    if (ph == 5 && sel != 2'd0) return T_BASE << (sel - 1);
    return T_ON + T_OFF;
  endfunction

  function automatic string autoTag(input int ph, input logic ext, input logic [1:0] sel,
                                    input logic inh, input logic ov);
    if (ov) return "R7";
    case (ph)
      2: return "R4";
      3: return ext ? "R3" : "R2";
      4: return (sel != 0 && !inh) ? "R4" : "R6";
      5: return (sel != 0 && !inh) ? "R5" : "R6";
      default: return "R8";
    endcase
  endfunction

  // one clock cycle: drive at negedge, check combinational path, then the edge result
  task automatic step(input int ph, input logic ext, input logic tick, input logic [1:0] sel,
                      input logic inh, input logic lo, input logic hi, input logic ov,
                      input string tagIn);
    bit   newPh;
    int   p;
    logic held;
    logic en;
    logic nxt;
    string tag;
    @(negedge clk);
    phaseIn = 3'(ph); extGate = ext; usTick = tick; trickleSel = sel;
    displayInhibit = inh; senseLow = lo; senseHigh = hi; overVolt = ov;
    tag = (tagIn == "") ? autoTag(ph, ext, sel, inh, ov) : tagIn;
    #1;
    check(ov ? "R7" : tag, gateOut, mReg & ~ov);
    newPh = (ph != mLast);
    p    = newPh ? 0 : mPos;
    held = newPh ? 1'b0 : mReg;
    en   = (sel != 2'd0) && !inh;
    case (ph)
      2: nxt = (p < T_ON);
      3: nxt = ext ? 1'b1 : (lo ? 1'b1 : (hi ? 1'b0 : held));
      4, 5: nxt = en && (p < T_ON);
      default: nxt = 1'b0;
    endcase
    mReg = nxt & ~ov;
    if (newPh) mPos = 0;
    else if (tick && (ph == 2 || ph == 4 || ph == 5))
      mPos = (p >= periodOf(ph, sel) - 1) ? 0 : p + 1;
    mLast = ph;
    @(posedge clk);
    #1;
    check(tag, gateOut, mReg & ~ov);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    // R1: reset holds the gate low even with fast charge requested
    phaseIn = 3'd3; senseLow = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R1", gateOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1; phaseIn = 3'd0; senseLow = 1'b0;
    @(posedge clk);
    #1 check("R1", gateOut, 1'b0);
    mPos = 0; mReg = 1'b0; mLast = 0;

    // R4: two full hold-off periods with a tick every cycle
    for (int i = 0; i < 2 * (T_ON + T_OFF); i++) step(2, 0, 1, 2'd1, 0, 0, 0, 0, "R4");
    // R9: top-off mid-train then straight into trickle, fresh on-slot
    for (int i = 0; i < 5; i++) step(4, 0, 1, 2'd1, 0, 0, 0, 0, "R4");
    step(5, 0, 1, 2'd3, 0, 0, 0, 0, "R9");
    // R5: trickle at 4x base period, two periods
    for (int i = 0; i < 2 * 4 * T_BASE; i++) step(5, 0, 1, 2'd3, 0, 0, 0, 0, "R5");
    // R10: no ticks, level frozen
    for (int i = 0; i < 20; i++) step(5, 0, 0, 2'd3, 0, 0, 0, 0, "R10");
    // R6: select zero and display inhibit suppress top-off
    for (int i = 0; i < 10; i++) step(4, 0, 1, 2'd0, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 10; i++) step(5, 0, 1, 2'd2, 1, 0, 0, 0, "R6");
    // R2: hysteresis low, band, high, band
    step(3, 0, 1, 2'd1, 0, 0, 0, 0, "R2");
    step(3, 0, 1, 2'd1, 0, 1, 1, 0, "R2");
    step(3, 0, 1, 2'd1, 0, 0, 0, 0, "R2");
    step(3, 0, 1, 2'd1, 0, 0, 1, 0, "R2");
    step(3, 0, 1, 2'd1, 0, 0, 0, 0, "R2");
    // R7: over-voltage blanks immediately and clears held level
    step(3, 0, 1, 2'd1, 0, 1, 0, 0, "R2");
    step(3, 0, 1, 2'd1, 0, 0, 0, 1, "R7");
    step(3, 0, 1, 2'd1, 0, 0, 0, 0, "R7");
    // R3: gated external source ignores sense flags
    step(3, 1, 1, 2'd1, 0, 0, 1, 0, "R3");
    step(3, 1, 1, 2'd1, 0, 0, 1, 0, "R3");
    // R8: quiet phases
    step(7, 0, 1, 2'd1, 0, 1, 0, 0, "R8");
    step(1, 0, 1, 2'd1, 0, 1, 0, 0, "R8");

    // constrained random segments
    for (int seg = 0; seg < 300; seg++) begin
      int ph;
      int len;
      logic ext;
      logic inh;
      logic [1:0] sel;
      ph  = $urandom % 8;
      len = 5 + ($urandom % 70);
      ext = ($urandom % 3) == 0;
      inh = ($urandom % 5) == 0;
      sel = 2'($urandom % 4);
      for (int c = 0; c < len; c++) begin
        step(ph, ext, ($urandom % 4) != 0, sel, inh,
             ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 50) == 0, "");
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule